// File: doc/BRIEF.md
# Viterbi Survivor Shift-Store Unit

This unit produces the memory writes for the survivor-store step of a Viterbi add-compare-select loop. A start command carries a variant code, a bank bit, two banks of four 32-bit register values, four decision flags, an endian bit, a base address and a post-increment. For each of two survivor words, a flag picks a 16-bit half from one of two registers. That half is shifted left by one, and a fixed decision bit is appended. The bit shifted out of the top is lost.

The command is registered. In the next cycle the unit presents all write slots at once, each with its own valid, address and data, together with a single-cycle done pulse and the post-incremented address. Memory and the register file lie outside the unit. A new command is accepted only when the unit is idle.

Top module: `vit_survivor_store`

## Requirements
- R1: After reset, `done_o` is 0, `wr_valid_o` is 0 and `ready_o` is 1.
- R2: A start accepted while `ready_o` is 1 produces exactly one cycle of `done_o` on the following cycle, carrying the write slots. `wr_valid_o` is 0 whenever `done_o` is 0.
- R3: A start seen while `done_o` is high (`ready_o` 0) is ignored. It produces no done pulse and no writes.
- R4: Variant code 0 writes four words from the low halves and code 1 writes four words from the high halves. In both, slot 0 holds the selected half of register 0 and slot 1 holds the selected half of register 1, each unshifted.
- R5: Two survivor words are formed. Each takes the selected half of register 3 when its flag is 1, otherwise of register 2. The half is shifted left by one, the old MSB is dropped, and a fixed bit is put in the LSB. The survivor with LSB 0 goes to slot 2 and the survivor with LSB 1 goes to slot 3 in four-word variants.
- R6: Low-half variants use flag bit 0 for the LSB-0 survivor and flag bit 2 for the LSB-1 survivor. High-half variants use flag bits 1 and 3.
- R7: Variant code 2 (low halves) and code 3 (high halves) write only the two survivors. The LSB-0 word goes in slot 0 and the LSB-1 word in slot 1, with `wr_valid_o` = 4'b0011. Four-word variants give 4'b1111.
- R8: With `big_endian_i` = 1, slots 0..3 go to base+2, base, base+6 and base+4. With 0, they go to base, base+2, base+4 and base+6. All sums wrap modulo 2^32.
- R9: `addr_next_o` during done equals base + increment, modulo 2^32.
- R10: `bank_i` = 0 takes all four registers from `bank0_regs_i`, and 1 takes them from `bank1_regs_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Command strobe |
| ready_o | output | 1 | Idle, a start will be accepted |
| variant_i | input | 2 | 0 four-word low, 1 four-word high, 2 two-word low, 3 two-word high |
| bank_i | input | 1 | Register bank select |
| bank0_regs_i | input | 4x32 | Bank 0 registers, index 0..3 |
| bank1_regs_i | input | 4x32 | Bank 1 registers, index 0..3 |
| vflag_i | input | 4 | Decision flags, bit n is flag n |
| big_endian_i | input | 1 | Word order select |
| base_i | input | 32 | Base address |
| incr_i | input | 32 | Post-increment |
| done_o | output | 1 | Write slots valid this cycle |
| wr_valid_o | output | 4 | Per-slot write valid |
| wr_addr_o | output | 4x32 | Per-slot address |
| wr_data_o | output | 4x16 | Per-slot data |
| addr_next_o | output | 32 | Post-incremented address |

## Verification
Command acceptance and result presentation can fall in the same cycle. During the done pulse of one command, another start may already be on the inputs. The bench provokes this by holding start high across three consecutive cycles with three different commands. The scoreboard expects the first and third to appear, and expects nothing from the middle one. Any extra done pulse, one with an empty queue, or a high `ready_o` while done is up is reported against R3.

// File: rtl/vss_pkg.sv
package vss_pkg;
  localparam int SLOTS = 4;

  typedef enum logic [1:0] {
    VAR_QUAD_LO = 2'd0,
    VAR_QUAD_HI = 2'd1,
    VAR_PAIR_LO = 2'd2,
    VAR_PAIR_HI = 2'd3
  } variant_e;
endpackage

// File: rtl/vss_half_pick.sv
module vss_half_pick #(
  parameter int REG_W = 32,
  localparam int HALF_W = REG_W / 2
) (
  input  logic [REG_W-1:0]  main_reg_i,
  input  logic [REG_W-1:0]  alt_reg_i,
  input  logic              hi_i,
  input  logic              flag_i,
  input  logic              dbit_i,
  output logic [HALF_W-1:0] word_o
);
  function automatic logic [HALF_W-1:0] take_half(logic [REG_W-1:0] r, logic hi);
    return hi ? r[REG_W-1:HALF_W] : r[HALF_W-1:0];
  endfunction

  function automatic logic [HALF_W-1:0] shift_in(logic [HALF_W-1:0] h, logic b);
    return {h[HALF_W-2:0], b};
  endfunction

  logic [REG_W-1:0]  chosen_reg;
  logic [HALF_W-1:0] chosen_half;

  assign chosen_reg  = flag_i ? alt_reg_i : main_reg_i;
  assign chosen_half = take_half(chosen_reg, hi_i);
  assign word_o      = shift_in(chosen_half, dbit_i);
endmodule

// File: rtl/vss_addr_gen.sv
module vss_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int SLOTS  = 4,
  parameter int STEP   = 2
) (
  input  logic [ADDR_W-1:0]            base_i,
  input  logic [ADDR_W-1:0]            incr_i,
  input  logic                         big_i,
  output logic [SLOTS-1:0][ADDR_W-1:0] slot_addr_o,
  output logic [ADDR_W-1:0]            next_o
);
  function automatic logic [ADDR_W-1:0] slot_offset(int idx, logic big);
    int pos;
    pos = big ? (idx ^ 1) : idx;
    return ADDR_W'(pos) * ADDR_W'(STEP);
  endfunction

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign slot_addr_o[g] = base_i + slot_offset(g, big_i);
  end

  assign next_o = base_i + incr_i;

  always_comb begin
    if (!$isunknown(slot_addr_o))
      assert_span_R8: assert (slot_addr_o[2] - slot_addr_o[0] == ADDR_W'(2 * STEP));
  end
endmodule

// File: rtl/vit_survivor_store.sv
module vit_survivor_store
  import vss_pkg::*;
#(
  parameter int REG_W  = 32,
  parameter int ADDR_W = 32,
  localparam int HALF_W = REG_W / 2,
  localparam int STEP   = HALF_W / 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  output logic                          ready_o,
  input  logic [1:0]                    variant_i,
  input  logic                          bank_i,
  input  logic [SLOTS-1:0][REG_W-1:0]   bank0_regs_i,
  input  logic [SLOTS-1:0][REG_W-1:0]   bank1_regs_i,
  input  logic [3:0]                    vflag_i,
  input  logic                          big_endian_i,
  input  logic [ADDR_W-1:0]             base_i,
  input  logic [ADDR_W-1:0]             incr_i,
  output logic                          done_o,
  output logic [SLOTS-1:0]              wr_valid_o,
  output logic [SLOTS-1:0][ADDR_W-1:0]  wr_addr_o,
  output logic [SLOTS-1:0][HALF_W-1:0]  wr_data_o,
  output logic [ADDR_W-1:0]             addr_next_o
);
  logic                        live_q;
  logic [1:0]                  var_q;
  logic [SLOTS-1:0][REG_W-1:0] regs_q;
  logic [3:0]                  flags_q;
  logic                        big_q;
  logic [ADDR_W-1:0]           base_q;
  logic [ADDR_W-1:0]           incr_q;

  logic accept_w;
  logic pair_w;
  logic hi_w;
  logic [1:0][HALF_W-1:0] surv_w;
  logic [1:0][HALF_W-1:0] plain_w;

  assign accept_w = start_i && !live_q;
  assign ready_o  = !live_q;
  assign done_o   = live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q  <= 1'b0;
      var_q   <= VAR_QUAD_LO;
      regs_q  <= '0;
      flags_q <= '0;
      big_q   <= 1'b0;
      base_q  <= '0;
      incr_q  <= '0;
    end else begin
      live_q <= accept_w;
      if (accept_w) begin
        var_q   <= variant_i;
        regs_q  <= bank_i ? bank1_regs_i : bank0_regs_i;
        flags_q <= vflag_i;
        big_q   <= big_endian_i;
        base_q  <= base_i;
        incr_q  <= incr_i;
      end
    end
  end

  assign pair_w = (var_q == VAR_PAIR_LO) || (var_q == VAR_PAIR_HI);
  assign hi_w   = (var_q == VAR_QUAD_HI) || (var_q == VAR_PAIR_HI);

  for (genvar s = 0; s < 2; s++) begin : g_surv
    logic flag_sel;
    assign flag_sel = hi_w ? flags_q[2*s+1] : flags_q[2*s];
    vss_half_pick #(.REG_W(REG_W)) u_pick (
      .main_reg_i (regs_q[2]),
      .alt_reg_i  (regs_q[3]),
      .hi_i       (hi_w),
      .flag_i     (flag_sel),
      .dbit_i     (s == 1),
      .word_o     (surv_w[s])
    );
  end

  for (genvar j = 0; j < 2; j++) begin : g_plain
    assign plain_w[j] = hi_w ? regs_q[j][REG_W-1:HALF_W] : regs_q[j][HALF_W-1:0];
  end

  vss_addr_gen #(.ADDR_W(ADDR_W), .SLOTS(SLOTS), .STEP(STEP)) u_addr (
    .base_i      (base_q),
    .incr_i      (incr_q),
    .big_i       (big_q),
    .slot_addr_o (wr_addr_o),
    .next_o      (addr_next_o)
  );

  always_comb begin
    if (pair_w) begin
      wr_data_o[0] = surv_w[0];
      wr_data_o[1] = surv_w[1];
      wr_data_o[2] = '0;
      wr_data_o[3] = '0;
    end else begin
      wr_data_o[0] = plain_w[0];
      wr_data_o[1] = plain_w[1];
      wr_data_o[2] = surv_w[0];
      wr_data_o[3] = surv_w[1];
    end
    if (!live_q)     wr_valid_o = '0;
    else if (pair_w) wr_valid_o = 4'b0011;
    else             wr_valid_o = 4'b1111;
  end

  assert_done_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> done_o);
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_quiet_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |-> (wr_valid_o == '0));
  assert_busy_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !ready_o) |=> !done_o);
  assert_pair_slots_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pair_w) |-> (wr_valid_o == 4'b0011));
  assert_dbits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !pair_w) |-> (wr_data_o[2][0] == 1'b0 && wr_data_o[3][0] == 1'b1));
  assert_next_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && ready_o) |=> (addr_next_o == $past(base_i) + $past(incr_i)));
endmodule

// File: tb/tb_vit_survivor_store.sv
module tb_vit_survivor_store;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic              start_i = 1'b0;
  logic              ready_o;
  logic [1:0]        variant_i = '0;
  logic              bank_i = 1'b0;
  logic [3:0][31:0]  bank0_regs_i = '0;
  logic [3:0][31:0]  bank1_regs_i = '0;
  logic [3:0]        vflag_i = '0;
  logic              big_endian_i = 1'b0;
  logic [31:0]       base_i = '0;
  logic [31:0]       incr_i = '0;
  logic              done_o;
  logic [3:0]        wr_valid_o;
  logic [3:0][31:0]  wr_addr_o;
  logic [3:0][15:0]  wr_data_o;
  logic [31:0]       addr_next_o;

  vit_survivor_store dut (.*);

  typedef struct {
    logic [3:0]       vld;
    logic [3:0][31:0] addr;
    logic [3:0][15:0] data;
    logic [31:0]      nxt;
    string            tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic exp_t model(logic [1:0] v, logic bk, logic [3:0][31:0] r0,
                                 logic [3:0][31:0] r1, logic [3:0] f, logic be,
                                 logic [31:0] base, logic [31:0] inc, string tag);
    exp_t e;
    logic [3:0][31:0] r;
    logic hi, two;
    logic [15:0] s0, s1, h;
    int offs[4];
    r   = bk ? r1 : r0;
    hi  = v[0];
    two = v[1];
    h  = 16'((f[0 + hi] ? r[3] : r[2]) >> (hi ? 16 : 0));
    s0 = 16'({h, 1'b0});
    h  = 16'((f[2 + hi] ? r[3] : r[2]) >> (hi ? 16 : 0));
    s1 = 16'({h, 1'b1});
    if (be) offs = '{2, 0, 6, 4}; else offs = '{0, 2, 4, 6};
    for (int i = 0; i < 4; i++) e.addr[i] = base + 32'(offs[i]);
    e.nxt = base + inc;
    e.tag = tag;
    if (two) begin
      e.vld = 4'b0011;
      e.data[0] = s0; e.data[1] = s1; e.data[2] = '0; e.data[3] = '0;
    end else begin
      e.vld = 4'b1111;
      e.data[0] = 16'(r[0] >> (hi ? 16 : 0));
      e.data[1] = 16'(r[1] >> (hi ? 16 : 0));
      e.data[2] = s0; e.data[3] = s1;
    end
    return e;
  endfunction

  task automatic put(logic [1:0] v, logic bk, logic [3:0][31:0] r0, logic [3:0][31:0] r1,
                     logic [3:0] f, logic be, logic [31:0] base, logic [31:0] inc,
                     string tag, bit expect_accept);
    variant_i = v; bank_i = bk; bank0_regs_i = r0; bank1_regs_i = r1;
    vflag_i = f; big_endian_i = be; base_i = base; incr_i = inc; start_i = 1'b1;
    if (expect_accept) sb_q.push_back(model(v, bk, r0, r1, f, be, base, inc, tag));
  endtask

  task automatic issue(logic [1:0] v, logic bk, logic [3:0][31:0] r0, logic [3:0][31:0] r1,
                       logic [3:0] f, logic be, logic [31:0] base, logic [31:0] inc, string tag);
    @(negedge clk);
    put(v, bk, r0, r1, f, be, base, inc, tag, 1'b1);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  function automatic logic [3:0][31:0] rnd_regs();
    logic [3:0][31:0] r;
    for (int i = 0; i < 4; i++) r[i] = $urandom;
    return r;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (done_o) begin
        chk(ready_o == 1'b0, "R3 ready low during done", 32'(ready_o), 32'd0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R3 unexpected done", 32'(done_o), 32'd0);
        end else begin
          exp_t e;
          e = sb_q.pop_front();
          chk(wr_valid_o == e.vld, {"R7 valid ", e.tag}, 32'(wr_valid_o), 32'(e.vld));
          for (int i = 0; i < 4; i++) begin
            if (e.vld[i]) begin
              chk(wr_data_o[i] == e.data[i], {"R5 data ", e.tag}, 32'(wr_data_o[i]), 32'(e.data[i]));
              chk(wr_addr_o[i] == e.addr[i], {"R8 addr ", e.tag}, wr_addr_o[i], e.addr[i]);
            end
          end
          chk(addr_next_o == e.nxt, {"R9 next ", e.tag}, addr_next_o, e.nxt);
        end
      end else begin
        chk(wr_valid_o == 4'b0000, "R2 valid without done", 32'(wr_valid_o), 32'd0);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [3:0][31:0] ra, rb;
    ra = {32'h8001_7FFF, 32'hC3C3_5A5A, 32'h1234_ABCD, 32'hFEDC_0123};
    rb = {32'h0F0F_F0F0, 32'hAAAA_5555, 32'h3333_CCCC, 32'h9999_6666};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(done_o == 1'b0, "R1 done", 32'(done_o), 32'd0);
    chk(wr_valid_o == 4'b0, "R1 valid", 32'(wr_valid_o), 32'd0);
    chk(ready_o == 1'b1, "R1 ready", 32'(ready_o), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    issue(2'd0, 1'b0, ra, rb, 4'b0000, 1'b0, 32'h1000, 32'h10, "R4 quad lo little");
    issue(2'd1, 1'b0, ra, rb, 4'b1111, 1'b1, 32'h2000, 32'h8, "R4 quad hi big");
    issue(2'd2, 1'b0, ra, rb, 4'b0101, 1'b0, 32'h3000, 32'h4, "R7 pair lo");
    issue(2'd3, 1'b0, ra, rb, 4'b1010, 1'b1, 32'h4000, 32'h4, "R7 pair hi big");
    issue(2'd0, 1'b1, ra, rb, 4'b0100, 1'b0, 32'h5000, 32'h20, "R10 bank1 quad lo");
    issue(2'd3, 1'b1, ra, rb, 4'b0010, 1'b1, 32'h5100, 32'h20, "R10 bank1 pair hi");
    issue(2'd1, 1'b0, {4{32'hFFFF_FFFF}}, rb, 4'b1001, 1'b0, 32'h6000, 32'h2, "R5 msb drop");
    issue(2'd0, 1'b0, ra, rb, 4'b0000, 1'b1, 32'hFFFF_FFFC, 32'h0000_0008, "R9 wrap big");
    issue(2'd2, 1'b0, ra, rb, 4'b1111, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R9 wrap pair");

    for (int f = 0; f < 16; f++)
      for (int v = 0; v < 4; v++)
        issue(2'(v), 1'(f & 1), ra, rb, 4'(f), 1'(v & 1), 32'h100 * 32'(f), 32'(v), "R6 flag sweep");

    // R3: start held over three cycles, middle command falls in the done cycle
    @(negedge clk);
    put(2'd0, 1'b0, ra, rb, 4'b0011, 1'b0, 32'h7000, 32'h4, "R3 first", 1'b1);
    @(negedge clk);
    put(2'd1, 1'b1, rb, ra, 4'b1100, 1'b1, 32'h7777, 32'h4, "R3 ignored", 1'b0);
    @(negedge clk);
    put(2'd2, 1'b0, rb, ra, 4'b0110, 1'b1, 32'h7100, 32'h4, "R3 third", 1'b1);
    @(negedge clk);
    start_i = 1'b0;

    for (int k = 0; k < 40; k++) begin
      ra = rnd_regs();
      rb = rnd_regs();
      issue(2'($urandom), 1'($urandom), ra, rb, 4'($urandom), 1'($urandom),
            $urandom, $urandom, "R5 random");
    end

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R2 missing done", 32'(sb_q.size()), 32'd0);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule